// File: doc/BRIEF.md
# EPP Host Cycle Engine

This block is the host side of an Enhanced Parallel Port. A host issues one byte transfer at a time through a small command interface: a start pulse, a two-bit transfer type and a write byte. The block then runs the pin-level handshake. It drives the active-low address or data strobe and the write line, and it drives the 8-bit bidirectional bus through an output enable. It completes the transfer when the peripheral's active-low wait line returns high. An address transfer picks a register inside the peripheral, and later data transfers act on that register.

A build-time parameter selects one of two handshake flavours. In the strict flavour the block waits until wait is low before it starts a transfer. In the relaxed flavour it starts at once and completes only on a low-to-high transition of wait. A watchdog ends any transfer that has not completed within a parameterised number of clocks. It sets a sticky timeout flag that the host clears by pulsing a clear input. Between transfers every pin follows the standard-port control inputs.

Top module: `epp_host_engine`

## Requirements
- R1: The transfer type `op` uses bit 0 = data (1) / address (0) and bit 1 = read (1) / write (0). During a transfer, data types pull only `n_dstrb` low and address types pull only `n_astrb` low.
- R2: During a transfer, `n_write` is low for writes and high for reads. For writes `pd_oe` is high with `pd_o` equal to the accepted write byte from before the strobe falls until after it rises. For reads `pd_oe` stays low.
- R3: On a read, the byte on `pd_i` at the moment the completing rise of wait is seen appears on `rd_data` while `done` is high.
- R4: With the strict handshake, a transfer requested while `n_wait` is high keeps both strobes high and `busy` high. Its strobe falls only after `n_wait` goes low.
- R5: With the relaxed handshake, the strobe falls without regard to `n_wait`. A strobe begun while `n_wait` is high stays low until `n_wait` has gone low and then high.
- R6: After wait rises, the strobe returns high, `done` pulses for exactly one cycle with both strobes high, and `busy` falls in the next cycle.
- R7: If `TIMEOUT_CYC` clocks of active transfer elapse without completion, the transfer is aborted. The strobes are released, `done` pulses and `timeout` becomes 1 in the same cycle.
- R8: `timeout` stays 1 until `clr_timeout` is pulsed, after which it reads 0.
- R9: A `start` that arrives while `busy` is high is ignored: no second transfer or `done` follows.
- R10: While idle, `n_dstrb`, `n_astrb` and `n_write` equal `spp_ctrl` bits 0, 1 and 2. `pd_o` equals `spp_data`, and `pd_oe` is the inverse of `spp_ctrl` bit 3 (1 = bus input).
- R11: Holding `rst_n` low at a clock edge, even mid-transfer, returns the block to idle with `busy`, `done` and `timeout` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one transfer (taken only when idle) |
| op | input | 2 | Transfer type, encoding in R1 |
| wdata | input | 8 | Byte for write transfers |
| clr_timeout | input | 1 | Pulse to clear the timeout flag |
| spp_ctrl | input | 4 | Idle pin levels and bus direction bit |
| spp_data | input | 8 | Idle byte driven on the bus |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion or abort pulse |
| rd_data | output | 8 | Byte captured by the last read |
| timeout | output | 1 | Sticky watchdog flag |
| n_dstrb | output | 1 | Data strobe, active low |
| n_astrb | output | 1 | Address strobe, active low |
| n_write | output | 1 | Low for write transfers |
| n_wait | input | 1 | Peripheral wait handshake, asynchronous |
| pd_o | output | 8 | Bus drive value |
| pd_oe | output | 1 | Bus output enable |
| pd_i | input | 8 | Bus sampled value |

## Verification
The bench builds two instances with `TIMEOUT_CYC` cut to 64. This brings a watchdog abort within a few dozen cycles instead of the 2500 that the default 10 µs at 250 MHz would need. One instance uses the strict handshake, so the hold-off while wait is high and a start ignored during that hold-off can be exercised. The other uses the relaxed handshake, so a strobe that starts against a high wait line, and a mid-transfer reset, can be observed at the pins.

// File: rtl/epp_pkg.sv
// Package: shared encodings for the EPP host engine.
// Assumes a 2-bit transfer type: bit0 selects data/address, bit1 read/write.
package epp_pkg;

    typedef enum logic [1:0] {
        OP_ADDR_WR = 2'b00,
        OP_DATA_WR = 2'b01,
        OP_ADDR_RD = 2'b10,
        OP_DATA_RD = 2'b11
    } epp_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SETUP  = 2'b01,
        ST_STROBE = 2'b10,
        ST_HOLD   = 2'b11
    } epp_state_e;

endpackage

// File: rtl/epp_wait_sync.sv
// Module: brings the asynchronous active-low wait line into the clock domain.
// Assumes STAGES >= 2; the output lags the pin by STAGES clocks.
module epp_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic n_wait,
    output logic wait_hi
);
    logic [STAGES-1:0] sync_q;

    // Shift the pin level through the synchronizer chain; reset to the idle-high level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], n_wait};
    end

    assign wait_hi = sync_q[STAGES-1];
endmodule

// File: rtl/epp_watchdog.sv
// Module: counts clocks while a transfer is active and flags expiry.
// Assumes LIMIT >= 2; the count restarts whenever run is low.
module epp_watchdog #(
    parameter int LIMIT = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt_q;

    // Advance the elapsed-time counter during active transfers only.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (!expire)   cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/epp_cycle_fsm.sv
// Module: sequences one EPP transfer and keeps the sticky timeout flag.
// Assumes wait_hi is already synchronized and expire comes from the watchdog.
module epp_cycle_fsm
    import epp_pkg::*;
#(
    parameter int DW  = 8,
    parameter bit V19 = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [DW-1:0] wdata,
    input  logic          clr_timeout,
    input  logic          wait_hi,
    input  logic          expire,
    input  logic [DW-1:0] pd_i,
    output epp_state_e    state,
    output logic [1:0]    op_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rd_data,
    output logic          timeout
);
    logic seen_low_q;
    logic go_strobe;
    logic finish;

    // Strict flavour starts only while wait is low; relaxed flavour starts at once.
    assign go_strobe = V19 ? !wait_hi : 1'b1;
    assign finish    = wait_hi && seen_low_q;

    // Transfer state machine with command latching and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            op_q       <= OP_ADDR_WR;
            wdata_q    <= '0;
            rd_data    <= '0;
            seen_low_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    seen_low_q <= 1'b0;
                    if (start) begin
                        op_q    <= op;
                        wdata_q <= wdata;
                        state   <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (expire) begin
                        state <= ST_HOLD;
                    end else if (go_strobe) begin
                        seen_low_q <= !wait_hi;
                        state      <= ST_STROBE;
                    end
                end
                ST_STROBE: begin
                    if (expire) begin
                        state <= ST_HOLD;
                    end else if (finish) begin
                        if (op_q[1]) rd_data <= pd_i;
                        state <= ST_HOLD;
                    end else if (!wait_hi) begin
                        seen_low_q <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Sticky timeout flag: set on abort, cleared by the host pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         timeout <= 1'b0;
        else if (expire && (state != ST_IDLE))              timeout <= 1'b1;
        else if (clr_timeout)                               timeout <= 1'b0;
    end
endmodule

// File: rtl/epp_host_engine.sv
// Module: top of the EPP host engine; muxes pins between transfer and idle control.
// Assumes n_wait is asynchronous and spp_ctrl/spp_data are stable register outputs.
module epp_host_engine
    import epp_pkg::*;
#(
    parameter int DW          = 8,
    parameter bit V19         = 1'b1,
    parameter int TIMEOUT_CYC = 2500,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [DW-1:0] wdata,
    input  logic          clr_timeout,
    input  logic [3:0]    spp_ctrl,
    input  logic [DW-1:0] spp_data,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          timeout,
    output logic          n_dstrb,
    output logic          n_astrb,
    output logic          n_write,
    input  logic          n_wait,
    output logic [DW-1:0] pd_o,
    output logic          pd_oe,
    input  logic [DW-1:0] pd_i
);
    epp_state_e    state;
    logic [1:0]    op_q;
    logic [DW-1:0] wdata_q;
    logic          wait_hi;
    logic          expire;
    logic          wd_run;
    logic          strobing;

    epp_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .n_wait  (n_wait),
        .wait_hi (wait_hi)
    );

    assign wd_run = (state == ST_SETUP) || (state == ST_STROBE);

    epp_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (wd_run),
        .expire (expire)
    );

    epp_cycle_fsm #(.DW(DW), .V19(V19)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .op          (op),
        .wdata       (wdata),
        .clr_timeout (clr_timeout),
        .wait_hi     (wait_hi),
        .expire      (expire),
        .pd_i        (pd_i),
        .state       (state),
        .op_q        (op_q),
        .wdata_q     (wdata_q),
        .rd_data     (rd_data),
        .timeout     (timeout)
    );

    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_HOLD);
    assign strobing = (state == ST_STROBE);

    // Pin mux: transfer signalling while busy, standard-port levels otherwise.
    always_comb begin
        if (busy) begin
            n_dstrb = !(strobing && op_q[0]);
            n_astrb = !(strobing && !op_q[0]);
            n_write = op_q[1];
            pd_oe   = !op_q[1];
            pd_o    = wdata_q;
        end else begin
            n_dstrb = spp_ctrl[0];
            n_astrb = spp_ctrl[1];
            n_write = spp_ctrl[2];
            pd_oe   = !spp_ctrl[3];
            pd_o    = spp_data;
        end
    end
endmodule

// File: rtl/epp_host_checker.sv
// Module: protocol assertions for the EPP host engine, bound to every instance.
// Assumes only the top-level ports; looks no further back than one cycle.
module epp_host_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic clr_timeout,
    input logic busy,
    input logic done,
    input logic timeout,
    input logic n_dstrb,
    input logic n_astrb,
    input logic n_write,
    input logic pd_oe
);
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (n_dstrb || n_astrb)); // R1
    AST_WRITE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !n_write) |-> pd_oe); // R2
    AST_READ_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && n_write) |-> !pd_oe); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R6
    AST_DONE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (n_dstrb && n_astrb)); // R6
    AST_TIMEOUT_WITH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> done); // R7
    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !clr_timeout) |=> timeout); // R8
    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R9
endmodule

bind epp_host_engine epp_host_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .clr_timeout (clr_timeout),
    .busy        (busy),
    .done        (done),
    .timeout     (timeout),
    .n_dstrb     (n_dstrb),
    .n_astrb     (n_astrb),
    .n_write     (n_write),
    .pd_oe       (pd_oe)
);

// File: tb/tb_epp_host_engine.sv
// Bench: scoreboard for the strict-handshake instance plus direct checks on a relaxed one.
module tb_epp_host_engine;
    localparam int TO = 64;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       start = 1'b0, clr_timeout = 1'b0, n_wait = 1'b0;
    logic [1:0] op = 2'b00;
    logic [7:0] wdata = 8'h00, spp_data = 8'h00, pd_i = 8'h00;
    logic [3:0] spp_ctrl = 4'b1111;
    logic       busy, done, timeout, n_dstrb, n_astrb, n_write, pd_oe;
    logic [7:0] rd_data, pd_o;

    logic       start17 = 1'b0, n_wait17 = 1'b1;
    logic [1:0] op17 = 2'b00;
    logic [7:0] pd_i17 = 8'h00;
    logic       busy17, done17, timeout17, n_dstrb17, n_astrb17, n_write17, pd_oe17;
    logic [7:0] rd_data17, pd_o17;

    epp_host_engine #(.V19(1'b1), .TIMEOUT_CYC(TO)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wdata(wdata),
        .clr_timeout(clr_timeout), .spp_ctrl(spp_ctrl), .spp_data(spp_data),
        .busy(busy), .done(done), .rd_data(rd_data), .timeout(timeout),
        .n_dstrb(n_dstrb), .n_astrb(n_astrb), .n_write(n_write), .n_wait(n_wait),
        .pd_o(pd_o), .pd_oe(pd_oe), .pd_i(pd_i));

    epp_host_engine #(.V19(1'b0), .TIMEOUT_CYC(TO)) dut17 (
        .clk(clk), .rst_n(rst_n), .start(start17), .op(op17), .wdata(8'h00),
        .clr_timeout(1'b0), .spp_ctrl(4'b1111), .spp_data(8'h00),
        .busy(busy17), .done(done17), .rd_data(rd_data17), .timeout(timeout17),
        .n_dstrb(n_dstrb17), .n_astrb(n_astrb17), .n_write(n_write17), .n_wait(n_wait17),
        .pd_o(pd_o17), .pd_oe(pd_oe17), .pd_i(pd_i17));

    int nchk = 0, nbad = 0;

    typedef struct { logic [7:0] data; bit cmp; bit to; } exp_t;
    exp_t q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop one expected item per done pulse and compare.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(timeout == e.to, "R7 timeout flag at done", timeout, e.to);
                if (e.cmp) chk(rd_data == e.data, "R3 read byte", rd_data, e.data);
            end
        end
    end

    // Driver plus peripheral model for the strict instance.
    task automatic run_op(input logic [1:0] o, input logic [7:0] wd, input logic [7:0] rd, input int hold);
        exp_t e;
        int k;
        e.data = rd; e.cmp = o[1]; e.to = 1'b0;
        q.push_back(e);
        pd_i = rd;
        if (hold > 0) n_wait = 1'b1;
        @(negedge clk); start = 1'b1; op = o; wdata = wd;
        @(negedge clk); start = 1'b0;
        if (hold > 0) begin
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                if (i == 2) begin start = 1'b1; op = ~o; wdata = ~wd; end
                else start = 1'b0;
            end
            chk(busy && n_dstrb && n_astrb, "R4 strobes held during hold-off",
                {busy, n_dstrb, n_astrb}, 3'b111);
            n_wait = 1'b0;
        end
        k = 0;
        while (n_dstrb && n_astrb && k < 50) begin @(negedge clk); k++; end
        chk(o[0] ? (!n_dstrb && n_astrb) : (n_dstrb && !n_astrb), "R1 strobe select",
            {n_dstrb, n_astrb}, o[0] ? 2'b01 : 2'b10);
        chk(n_write == o[1], "R2 write line", n_write, o[1]);
        chk(pd_oe == !o[1], "R2 bus enable", pd_oe, !o[1]);
        if (!o[1]) chk(pd_o == wd, "R2 write byte", pd_o, wd);
        repeat (4) @(negedge clk);
        chk(!(n_dstrb && n_astrb), "R6 strobe held until wait rises", {n_dstrb, n_astrb}, 0);
        n_wait = 1'b1;
        k = 0;
        while (busy && k < 50) begin @(negedge clk); k++; end
        chk(!busy && n_dstrb && n_astrb, "R6 transfer released", {busy, n_dstrb, n_astrb}, 3'b011);
        n_wait = 1'b0;
        repeat (6) @(negedge clk);
        chk(!busy, "R9 no extra transfer", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !timeout, "R11 reset state", {busy, done, timeout}, 0);
        chk(n_dstrb && n_astrb, "R11 strobes high in reset", {n_dstrb, n_astrb}, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: idle pins follow the standard-port inputs
        spp_ctrl = 4'b0101; spp_data = 8'h96;
        @(negedge clk);
        chk({n_write, n_astrb, n_dstrb, pd_oe} == 4'b1011 && pd_o == 8'h96, "R10 idle pattern A",
            {n_write, n_astrb, n_dstrb, pd_oe, pd_o}, {4'b1011, 8'h96});
        spp_ctrl = 4'b1010; spp_data = 8'h21;
        @(negedge clk);
        chk({n_write, n_astrb, n_dstrb, pd_oe} == 4'b0100 && pd_o == 8'h21, "R10 idle pattern B",
            {n_write, n_astrb, n_dstrb, pd_oe, pd_o}, {4'b0100, 8'h21});
        spp_ctrl = 4'b1111;

        // R1 R2 R3: the four transfer types
        run_op(2'b00, 8'h5A, 8'h00, 0);
        run_op(2'b01, 8'hC3, 8'h00, 0);
        run_op(2'b10, 8'h00, 8'h3C, 0);
        run_op(2'b11, 8'h00, 8'hA5, 0);

        // R4 R9: hold-off with an ignored second start
        run_op(2'b11, 8'h00, 8'h69, 20);

        // R7 R8: watchdog abort with wait never rising
        begin
            exp_t e;
            int n;
            e.data = 8'h00; e.cmp = 1'b0; e.to = 1'b1;
            q.push_back(e);
            n_wait = 1'b0;
            @(negedge clk); start = 1'b1; op = 2'b01; wdata = 8'h11;
            @(negedge clk); start = 1'b0;
            n = 1;
            while (busy && n < 300) begin @(negedge clk); n++; end
            chk(n >= TO && n <= TO + 6, "R7 abort time", n, TO);
            chk(n_dstrb && n_astrb && !busy, "R7 strobes released", {busy, n_dstrb, n_astrb}, 3'b011);
            repeat (10) @(negedge clk);
            chk(timeout, "R8 timeout sticky", timeout, 1);
            clr_timeout = 1'b1;
            @(negedge clk); clr_timeout = 1'b0;
            chk(!timeout, "R8 timeout cleared", timeout, 0);
        end

        // R5: relaxed instance starts against a high wait line
        begin
            int k;
            n_wait17 = 1'b1; pd_i17 = 8'h7E;
            @(negedge clk); start17 = 1'b1; op17 = 2'b10;
            @(negedge clk); start17 = 1'b0;
            repeat (2) @(negedge clk);
            chk(!n_astrb17 && n_dstrb17, "R5 strobe without wait check", {n_dstrb17, n_astrb17}, 2'b10);
            repeat (10) @(negedge clk);
            chk(!n_astrb17 && busy17, "R5 high wait does not finish", {busy17, n_astrb17}, 2'b10);
            n_wait17 = 1'b0;
            repeat (4) @(negedge clk);
            n_wait17 = 1'b1;
            k = 0;
            while (!done17 && k < 20) begin @(negedge clk); k++; end
            chk(done17 && rd_data17 == 8'h7E, "R5 R3 finish on rise with byte",
                {done17, rd_data17}, {1'b1, 8'h7E});
            repeat (3) @(negedge clk);

            // R11: reset in mid-transfer
            @(negedge clk); start17 = 1'b1; op17 = 2'b01;
            @(negedge clk); start17 = 1'b0;
            repeat (3) @(negedge clk);
            rst_n = 1'b0;
            repeat (2) @(negedge clk);
            chk(!busy17 && !done17 && n_dstrb17 && n_astrb17, "R11 mid-transfer reset",
                {busy17, done17, n_dstrb17, n_astrb17}, 4'b0011);
            rst_n = 1'b1;
        end

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R6 every transfer signalled done", q.size(), 0);
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule